// File: doc/BRIEF.md
# Pixel Sample Companding Stage (12-bit to 10-bit)

This stage sits in a pixel stream directly after the converter. It takes one 12-bit sample per clock along with a sample-valid flag and the frame and line markers. When companding is switched on, it squeezes each sample into a 10-bit code using four straight-line segments. The first segment keeps every step. The other three merge 2, 4 and 8 input steps into one output step. Dark pixels keep full resolution, and bright pixels, where shot noise dominates, give up quantisation steps they do not need. When companding is off, the stage drops the two least significant bits and passes the sample on as a plain 10-bit value.

The result is registered once. The sample-valid, frame and line flags pass through the same register, so they stay aligned with the code. A clock-enable input stalls the register. While it is low, every output keeps its value. The companding mode is taken per sample, in the same cycle as the sample it applies to.

Top module: `pix_compand_stage`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the edge clears `code_o`, `pix_vld_o`, `frame_vld_o` and `line_vld_o` to 0.
- R2: With companding on, inputs 0..255 produce a code equal to the input.
- R3: With companding on, inputs 256..511 produce 256 + ((x − 256) >> 1).
- R4: With companding on, inputs 512..2047 produce 384 + ((x − 512) >> 2).
- R5: With companding on, inputs 2048..4095 produce 768 + ((x − 2048) >> 3), so the code's two top bits are both 1.
- R6: With companding off, the code is the input's bits 11..2 (x >> 2).
- R7: With `en` high at a rising edge, the code and all three flags reflect that edge's inputs right after the edge: exactly one cycle of latency.
- R8: With `en` low at a rising edge, all four outputs keep their previous values, whatever the data, flag and mode inputs do.
- R9: With companding on, the code never decreases as the input increases over 0..4095.
- R10: `comp_on` is sampled together with the sample, so alternating the mode on consecutive samples alternates the mapping on consecutive outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Clock enable for the output register |
| comp_on | input | 1 | 1 = four-segment companding, 0 = truncating bypass |
| pix_vld_i | input | 1 | Sample valid |
| frame_vld_i | input | 1 | Frame marker |
| line_vld_i | input | 1 | Line marker |
| pix_i | input | 12 | Converter sample |
| pix_vld_o | output | 1 | Registered sample valid |
| frame_vld_o | output | 1 | Registered frame marker |
| line_vld_o | output | 1 | Registered line marker |
| code_o | output | 10 | Registered 10-bit code |

## Verification
A change of companding mode can arrive in the same cycle as a stall. It can also arrive in the same cycle as a new sample. The bench toggles `comp_on`, the data and the flags while `en` is low and requires the held outputs to stay bit-identical. It then releases the enable and requires the very next output to use the new mode. Separately, it alternates the mode on back-to-back samples, so that the mode and the data that enter in one cycle must be paired in the output of the next. Both exhaustive sweeps of the 4096 inputs, one per mode, compare every code against arithmetic in the bench, including the segment edges at 255/256, 511/512 and 2047/2048.

// File: rtl/pix_compand_pkg.sv
package pix_compand_pkg;

    localparam int PIX_W  = 12;
    localparam int CODE_W = 10;
    localparam int NSEG   = 4;

    // first input value of each segment
    function automatic int seg_start(int i);
        case (i)
            0:       return 0;
            1:       return 256;
            2:       return 512;
            default: return 2048;
        endcase
    endfunction

    // segment i merges 2**i input steps into one output step
    function automatic int seg_shift(int i);
        return i;
    endfunction

    // one past the last input value of each segment
    function automatic int seg_stop(int i);
        if (i >= NSEG - 1)
            return 1 << PIX_W;
        return seg_start(i + 1);
    endfunction

    // first output code of each segment, accumulated from lower segments
    function automatic int seg_base(int i);
        int acc;
        acc = 0;
        for (int k = 0; k < i; k++)
            acc = acc + ((seg_stop(k) - seg_start(k)) >> seg_shift(k));
        return acc;
    endfunction

endpackage

// File: rtl/pix_compand_seg.sv
module pix_compand_seg #(
    parameter int PIX_W  = 12,
    parameter int CODE_W = 10,
    parameter int START  = 0,
    parameter int STOP   = 256,
    parameter int SHIFT  = 0,
    parameter int BASE   = 0
) (
    input  logic [PIX_W-1:0]  pix_i,
    output logic              hit_o,
    output logic [CODE_W-1:0] code_o
);

    logic [PIX_W-1:0] offset;
    logic [PIX_W-1:0] scaled;

    always_comb begin
        hit_o  = (int'(pix_i) >= START) && (int'(pix_i) < STOP);
        offset = pix_i - PIX_W'(START);
        scaled = offset >> SHIFT;
        code_o = CODE_W'(PIX_W'(BASE) + scaled);
    end

endmodule

// File: rtl/pix_compand_select.sv
module pix_compand_select #(
    parameter int CODE_W = 10,
    parameter int NSEG   = 4
) (
    input  logic                         comp_on_i,
    input  logic [NSEG-1:0]              hit_i,
    input  logic [NSEG-1:0][CODE_W-1:0]  seg_code_i,
    input  logic [CODE_W-1:0]            bypass_i,
    output logic [CODE_W-1:0]            code_o
);

    logic [CODE_W-1:0] merged;

    always_comb begin
        merged = '0;
        for (int k = 0; k < NSEG; k++) begin
            if (hit_i[k])
                merged = merged | seg_code_i[k];
        end
        code_o = comp_on_i ? merged : bypass_i;
    end

endmodule

// File: rtl/pix_compand_reg.sv
module pix_compand_reg #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              vld_i,
    input  logic              fv_i,
    input  logic              lv_i,
    output logic [CODE_W-1:0] code_o,
    output logic              vld_o,
    output logic              fv_o,
    output logic              lv_o
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o <= '0;
            vld_o  <= 1'b0;
            fv_o   <= 1'b0;
            lv_o   <= 1'b0;
        end else if (en_i) begin
            code_o <= code_i;
            vld_o  <= vld_i;
            fv_o   <= fv_i;
            lv_o   <= lv_i;
        end
    end

endmodule

// File: rtl/pix_compand_stage.sv
module pix_compand_stage
    import pix_compand_pkg::*;
#(
    parameter int IN_W  = PIX_W,
    parameter int OUT_W = CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             comp_on,
    input  logic             pix_vld_i,
    input  logic             frame_vld_i,
    input  logic             line_vld_i,
    input  logic [IN_W-1:0]  pix_i,
    output logic             pix_vld_o,
    output logic             frame_vld_o,
    output logic             line_vld_o,
    output logic [OUT_W-1:0] code_o
);

    localparam int SEGS = NSEG;

    logic [SEGS-1:0]             seg_hit;
    logic [SEGS-1:0][OUT_W-1:0]  seg_code;
    logic [OUT_W-1:0]            bypass_code;
    logic [OUT_W-1:0]            next_code;

    assign bypass_code = pix_i[IN_W-1 -: OUT_W];

    for (genvar g = 0; g < SEGS; g++) begin : g_seg
        pix_compand_seg #(
            .PIX_W  (IN_W),
            .CODE_W (OUT_W),
            .START  (seg_start(g)),
            .STOP   (seg_stop(g)),
            .SHIFT  (seg_shift(g)),
            .BASE   (seg_base(g))
        ) u_seg (
            .pix_i  (pix_i),
            .hit_o  (seg_hit[g]),
            .code_o (seg_code[g])
        );
    end

    pix_compand_select #(
        .CODE_W (OUT_W),
        .NSEG   (SEGS)
    ) u_sel (
        .comp_on_i  (comp_on),
        .hit_i      (seg_hit),
        .seg_code_i (seg_code),
        .bypass_i   (bypass_code),
        .code_o     (next_code)
    );

    pix_compand_reg #(
        .CODE_W (OUT_W)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en),
        .code_i (next_code),
        .vld_i  (pix_vld_i),
        .fv_i   (frame_vld_i),
        .lv_i   (line_vld_i),
        .code_o (code_o),
        .vld_o  (pix_vld_o),
        .fv_o   (frame_vld_o),
        .lv_o   (line_vld_o)
    );

endmodule

// File: rtl/pix_compand_chk.sv
module pix_compand_chk #(
    parameter int IN_W  = 12,
    parameter int OUT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             comp_on,
    input logic             pix_vld_i,
    input logic             frame_vld_i,
    input logic             line_vld_i,
    input logic [IN_W-1:0]  pix_i,
    input logic             pix_vld_o,
    input logic             frame_vld_o,
    input logic             line_vld_o,
    input logic [OUT_W-1:0] code_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (code_o == '0 && !pix_vld_o && !frame_vld_o && !line_vld_o));

    // R7
    flag_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (pix_vld_o == $past(pix_vld_i) && frame_vld_o == $past(frame_vld_i)
                && line_vld_o == $past(line_vld_i)));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(code_o) && $stable(pix_vld_o) && $stable(frame_vld_o)
                 && $stable(line_vld_o)));

    // R2
    linear_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && comp_on && int'(pix_i) < 256) |=> (int'(code_o) == int'($past(pix_i))));

    // R5
    top_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && comp_on && pix_i[IN_W-1]) |=> (code_o[OUT_W-1:OUT_W-2] == 2'b11));

    // R6
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !comp_on) |=> (code_o == $past(pix_i[IN_W-1 -: OUT_W])));

endmodule

bind pix_compand_stage pix_compand_chk #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .comp_on     (comp_on),
    .pix_vld_i   (pix_vld_i),
    .frame_vld_i (frame_vld_i),
    .line_vld_i  (line_vld_i),
    .pix_i       (pix_i),
    .pix_vld_o   (pix_vld_o),
    .frame_vld_o (frame_vld_o),
    .line_vld_o  (line_vld_o),
    .code_o      (code_o)
);

// File: tb/pix_compand_stage_tb.sv
module pix_compand_stage_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic       comp_on = 1'b0;
    logic       pix_vld_i = 1'b0;
    logic       frame_vld_i = 1'b0;
    logic       line_vld_i = 1'b0;
    logic [11:0] pix_i = '0;
    logic       pix_vld_o, frame_vld_o, line_vld_o;
    logic [9:0] code_o;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_compand_stage u_dut (
        .clk (clk), .rst_n (rst_n), .en (en), .comp_on (comp_on),
        .pix_vld_i (pix_vld_i), .frame_vld_i (frame_vld_i), .line_vld_i (line_vld_i),
        .pix_i (pix_i), .pix_vld_o (pix_vld_o), .frame_vld_o (frame_vld_o),
        .line_vld_o (line_vld_o), .code_o (code_o)
    );

    function automatic int expect_code(int x, bit on);
        if (!on)      return x / 4;
        if (x < 256)  return x;
        if (x < 512)  return 256 + (x - 256) / 2;
        if (x < 2048) return 384 + (x - 512) / 4;
        return 768 + (x - 2048) / 8;
    endfunction

    function automatic string seg_req(int x, bit on);
        if (!on)      return "R6";
        if (x < 256)  return "R2";
        if (x < 512)  return "R3";
        if (x < 2048) return "R4";
        return "R5";
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input int x, input bit on, input bit v, input bit f, input bit l);
        pix_i = 12'(x); comp_on = on; pix_vld_i = v; frame_vld_i = f; line_vld_i = l;
    endtask

    initial begin
        int prev;
        int held;
        // R1: drive active inputs during reset, outputs must stay cleared
        drive(4095, 1'b1, 1'b1, 1'b1, 1'b1);
        repeat (4) @(negedge clk);
        chk("R1 code", int'(code_o), 0);
        chk("R1 flags", int'({pix_vld_o, frame_vld_o, line_vld_o}), 0);
        rst_n = 1'b1;

        // companding sweep, with flag patterns (R2..R5, R7, R9)
        prev = -1;
        for (int x = 0; x < 4096; x++) begin
            drive(x, 1'b1, x[0] ^ x[3], x[5], x[1]);
            @(negedge clk);
            chk(seg_req(x, 1'b1), int'(code_o), expect_code(x, 1'b1));
            chk("R7 flags", int'({pix_vld_o, frame_vld_o, line_vld_o}),
                int'({x[0] ^ x[3], x[5], x[1]}));
            if (int'(code_o) < prev)
                chk("R9 monotonic", int'(code_o), prev);
            else
                checks++;
            prev = int'(code_o);
        end

        // bypass sweep (R6)
        for (int x = 0; x < 4096; x++) begin
            drive(x, 1'b0, x[2], x[4], x[6]);
            @(negedge clk);
            chk(seg_req(x, 1'b0), int'(code_o), expect_code(x, 1'b0));
            chk("R7 flags", int'({pix_vld_o, frame_vld_o, line_vld_o}),
                int'({x[2], x[4], x[6]}));
        end

        // mode alternating per sample (R10)
        for (int k = 0; k < 64; k++) begin
            int x;
            x = (k * 61 + 5) % 4096 + (k % 4) * 1000 % 4096;
            x = x % 4096;
            drive(x, k[0], 1'b1, 1'b1, 1'b1);
            @(negedge clk);
            chk("R10", int'(code_o), expect_code(x, k[0]));
        end

        // stall with mode change (R8), then release (R10)
        drive(3000, 1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk);
        held = int'(code_o);
        chk("R5", held, expect_code(3000, 1'b1));
        en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            drive(100 + k * 7, 1'b0, k[0], ~k[0], k[1]);
            @(negedge clk);
            chk("R8 code", int'(code_o), held);
            chk("R8 flags", int'({pix_vld_o, frame_vld_o, line_vld_o}), int'(3'b101));
        end
        en = 1'b1;
        drive(1500, 1'b0, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R10 release", int'(code_o), expect_code(1500, 1'b0));
        chk("R7 release flags", int'({pix_vld_o, frame_vld_o, line_vld_o}), int'(3'b010));

        // R1 again mid-stream
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rerun", int'({code_o, pix_vld_o, frame_vld_o, line_vld_o}), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule